// File: doc/BRIEF.md
# Predicated Data-Processing ALU

This block is the execute stage of a 32-bit integer datapath. Each clock cycle it takes one data-processing operation: a 4-bit opcode, a first operand, a second operand that an upstream shifter has already prepared, the carry bit from that shifter, a set-flags bit and a 4-bit condition code. The block holds four status flags in a register: negative, zero, carry and overflow. It tests the condition code against those stored flags. The result of the operation is always present at the result port. When the condition passes, the block asserts the write-enable for the destination register. It also updates the flags, either because the opcode is a compare-type operation or because the set-flags bit is 1.

A condition that fails turns the operation into a no-op. The write-enable stays low and the flags keep their values. Upstream logic can therefore use condition code 1111 to issue an idle cycle. The flags change on the rising clock edge that ends the cycle in which the operation is presented. That operation's result and write-enable are combinational and appear in the same cycle.

Top module: `cond_alu`

## Requirements
- R1: Logical opcodes produce the following results: 0000 gives op_a AND op_b, 0001 gives op_a XOR op_b, 1100 gives op_a OR op_b, and 1110 gives op_a AND NOT op_b.
- R2: Arithmetic opcodes produce the following results modulo 2^32: 0100 gives op_a + op_b, 0010 gives op_a - op_b, and 0011 gives op_b - op_a.
- R3: Carry-using opcodes read the stored C flag: 0101 gives op_a + op_b + C, 0110 gives op_a - op_b + C - 1, and 0111 gives op_b - op_a + C - 1.
- R4: The compare opcodes always update the flags and never assert result_we. They are 1000 (flags from AND), 1001 (flags from XOR), 1010 (flags from op_a - op_b) and 1011 (flags from op_a + op_b). Their value still appears on result.
- R5: All opcodes other than the compare opcodes assert result_we when the condition passes. They change the flags only if set_flags is 1.
- R6: On a flag update, N takes bit 31 of the value and Z is 1 exactly when the 32-bit value is zero.
- R7: On an arithmetic flag update, C is the carry out of bit 31 of the adder. For subtraction this means 1 when there is no borrow. V is signed two's-complement overflow.
- R8: On a logical flag update, C takes shift_carry and V keeps its previous value.
- R9: The condition codes are tested against the stored flags as follows: 0000 Z; 0001 !Z; 0010 C; 0011 !C; 0100 N; 0101 !N; 0110 V; 0111 !V; 1000 C&!Z; 1001 !C|Z; 1010 N==V; 1011 N!=V; 1100 !Z&(N==V); 1101 Z|(N!=V); 1110 always.
- R10: Condition code 1111 never passes. When a condition fails, result_we is 0 and the flags are unchanged at the next edge.
- R11: Reset clears the flags to 0000. The flags port is ordered {N, Z, C, V} from bit 3 down to bit 0.
- R12: Opcodes 1101 (result op_b) and 1111 (result NOT op_b) ignore op_a completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opcode | input | 4 | Data-processing operation |
| cond | input | 4 | Condition code tested against stored flags |
| set_flags | input | 1 | Request flag update for non-compare opcodes |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Shifted second operand |
| shift_carry | input | 1 | Carry out of the upstream shifter |
| result | output | 32 | Value of the operation |
| result_we | output | 1 | Destination write-enable |
| flags | output | 4 | Stored {N, Z, C, V} |

## Verification
The bench targets the carry-in paths of the subtract-with-carry forms. A design that inverts the stored carry there returns values that are off by one in every SBC and RSC. It also targets subtraction with a borrow, such as 0 - 1. A design that reports a raw carry-out as a borrow leaves C wrong, and conditions HI and LS then misjudge unsigned ordering. Signed overflow at 0x7FFFFFFF + 1 and at 0x80000000 - 1 exposes a V computed from the wrong sign bits. The bench also covers logical operations with set_flags, which must preserve V and take C from the shifter, and compare operations, which must never write the destination. It sweeps all sixteen condition codes against random flag states, including code 1111, so an inverted or swapped condition encoding shows up as a stray write-enable or a stray flag change.

// File: rtl/cond_alu.sv
module cond_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   opcode,
  input  logic [3:0]   cond,
  input  logic         set_flags,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         shift_carry,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic [3:0]   flags
);
  logic fn, fz, fc, fv;
  assign {fn, fz, fc, fv} = flags;

  logic cond_ok;
  always_comb begin
    case (cond)
      4'h0: cond_ok = fz;
      4'h1: cond_ok = !fz;
      4'h2: cond_ok = fc;
      4'h3: cond_ok = !fc;
      4'h4: cond_ok = fn;
      4'h5: cond_ok = !fn;
      4'h6: cond_ok = fv;
      4'h7: cond_ok = !fv;
      4'h8: cond_ok = fc && !fz;
      4'h9: cond_ok = !fc || fz;
      4'hA: cond_ok = (fn == fv);
      4'hB: cond_ok = (fn != fv);
      4'hC: cond_ok = !fz && (fn == fv);
      4'hD: cond_ok = fz || (fn != fv);
      4'hE: cond_ok = 1'b1;
      default: cond_ok = 1'b0;
    endcase
  end

  logic is_cmp, is_arith;
  assign is_cmp   = (opcode[3:2] == 2'b10);
  assign is_arith = (opcode[3:2] == 2'b01) || (opcode == 4'h2) || (opcode == 4'h3)
                    || (opcode == 4'hA) || (opcode == 4'hB);

  logic [W-1:0] add_x, add_y;
  logic         add_ci;
  always_comb begin
    add_x  = op_a;
    add_y  = op_b;
    add_ci = 1'b0;
    case (opcode)
      4'h2, 4'hA: begin add_y = ~op_b; add_ci = 1'b1; end
      4'h3:       begin add_x = op_b; add_y = ~op_a; add_ci = 1'b1; end
      4'h5:       add_ci = fc;
      4'h6:       begin add_y = ~op_b; add_ci = fc; end
      4'h7:       begin add_x = op_b; add_y = ~op_a; add_ci = fc; end
      default: ;
    endcase
  end

  logic [W:0] sum;
  assign sum = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_ci};

  logic add_v;
  assign add_v = (add_x[W-1] == add_y[W-1]) && (sum[W-1] != add_x[W-1]);

  always_comb begin
    case (opcode)
      4'h0, 4'h8: result = op_a & op_b;
      4'h1, 4'h9: result = op_a ^ op_b;
      4'hC:       result = op_a | op_b;
      4'hD:       result = op_b;
      4'hE:       result = op_a & ~op_b;
      4'hF:       result = ~op_b;
      default:    result = sum[W-1:0];
    endcase
  end

  logic upd;
  assign result_we = cond_ok && !is_cmp;
  assign upd       = cond_ok && (is_cmp || set_flags);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flags <= 4'b0000;
    else if (upd)
      flags <= {result[W-1], result == '0,
                is_arith ? sum[W] : shift_carry,
                is_arith ? add_v  : fv};
  end

  p_fail_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_ok |=> $stable(flags));
  p_never_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 4'hF) |-> !result_we);
  p_cmp_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_ok && is_cmp) |-> !result_we);
  p_noset_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_ok && !is_cmp && !set_flags) |=> $stable(flags));
  p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (flags[2] == ($past(result) == '0)));
  p_logic_cv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !is_arith) |=> (flags[1] == $past(shift_carry)) && (flags[0] == $past(flags[0])));
endmodule

// File: tb/tb_cond_alu.sv
module tb_cond_alu;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  opcode = 0, cond = 4'hF;
  logic        set_flags = 0, shift_carry = 0;
  logic [31:0] op_a = 0, op_b = 0;
  logic [31:0] result;
  logic        result_we;
  logic [3:0]  flags;

  int checks = 0, errors = 0;
  logic [3:0] mflags = 0;

  always #10 clk = ~clk;

  cond_alu dut (.clk(clk), .rst_n(rst_n), .opcode(opcode), .cond(cond),
    .set_flags(set_flags), .op_a(op_a), .op_b(op_b), .shift_carry(shift_carry),
    .result(result), .result_we(result_we), .flags(flags));

  function automatic bit pass_f(input logic [3:0] c, input logic [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      0: return z;          1: return !z;
      2: return cy;         3: return !cy;
      4: return n;          5: return !n;
      6: return v;          7: return !v;
      8: return cy && !z;   9: return !cy || z;
      10: return n == v;    11: return n != v;
      12: return !z && n == v; 13: return z || n != v;
      14: return 1;         default: return 0;
    endcase
  endfunction

  // returns {we, newflags, result}
  function automatic logic [36:0] model(input logic [3:0] op, input logic [3:0] c,
      input bit s, input logic [31:0] a, input logic [31:0] b, input bit shc,
      input logic [3:0] f);
    logic [32:0] wide;
    logic [31:0] r;
    bit arith = 1, cy = 0, v = 0, ok, cmp, upd;
    logic [3:0] nf = f;
    case (op)
      0, 8:  begin r = a & b;  arith = 0; end
      1, 9:  begin r = a ^ b;  arith = 0; end
      12:    begin r = a | b;  arith = 0; end
      13:    begin r = b;      arith = 0; end
      14:    begin r = a & ~b; arith = 0; end
      15:    begin r = ~b;     arith = 0; end
      4, 11: begin wide = {1'b0,a} + {1'b0,b}; r = wide[31:0]; cy = wide[32];
                   v = (a[31] == b[31]) && (r[31] != a[31]); end
      5:     begin wide = {1'b0,a} + {1'b0,b} + f[1]; r = wide[31:0]; cy = wide[32];
                   v = (a[31] == b[31]) && (r[31] != a[31]); end
      2, 10: begin r = a - b; cy = (a >= b);
                   v = (a[31] != b[31]) && (r[31] != a[31]); end
      3:     begin r = b - a; cy = (b >= a);
                   v = (a[31] != b[31]) && (r[31] != b[31]); end
      6:     begin r = a - b - {31'b0, !f[1]}; cy = ({1'b0,a} >= {1'b0,b} + !f[1]);
                   v = (a[31] != b[31]) && (r[31] != a[31]); end
      default: begin r = b - a - {31'b0, !f[1]}; cy = ({1'b0,b} >= {1'b0,a} + !f[1]);
                   v = (a[31] != b[31]) && (r[31] != b[31]); end
    endcase
    ok  = pass_f(c, f);
    cmp = (op[3:2] == 2'b10);
    upd = ok && (cmp || s);
    if (upd) nf = {r[31], r == 0, arith ? cy : shc, arith ? v : f[0]};
    return {ok && !cmp, nf, r};
  endfunction

  function automatic string tag(input logic [3:0] op);
    case (op)
      0, 1, 12, 14: return "R1";
      2, 3, 4:      return "R2";
      5, 6, 7:      return "R3";
      8, 9, 10, 11: return "R4";
      default:      return "R12";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (op %h cond %h s %0d a %h b %h)",
               req, act, exp, opcode, cond, set_flags, op_a, op_b);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic [3:0] c, input bit s,
                      input logic [31:0] a, input logic [31:0] b, input bit shc);
    logic [36:0] m;
    string ftag;
    @(negedge clk);
    opcode = op; cond = c; set_flags = s; op_a = a; op_b = b; shift_carry = shc;
    #1;
    m = model(op, c, s, a, b, shc, mflags);
    chk(tag(op), result, m[31:0]);
    chk(pass_f(c, mflags) ? "R9" : "R10", {31'b0, result_we}, {31'b0, m[36]});
    @(posedge clk); #1;
    if (!pass_f(c, mflags)) ftag = "R10";
    else if (op[3:2] != 2'b10 && !s) ftag = "R5";
    else if (op == 0 || op == 1 || op >= 12 || op == 8 || op == 9) ftag = "R8";
    else ftag = "R7";
    chk(ftag, {28'b0, flags}, {28'b0, m[35:32]});
    mflags = m[35:32];
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    #25;
    chk("R11", {28'b0, flags}, 32'h0);
    rst_n = 1;
    // R7 signed overflow on add, R6 N set
    step(4'h4, 4'hE, 1, 32'h7FFF_FFFF, 32'h1, 0);
    // R7 borrow: 0-1 clears C
    step(4'h2, 4'hE, 1, 32'h0, 32'h1, 0);
    // R6 zero result, R7 no-borrow on equal compare
    step(4'hA, 4'hE, 0, 32'h1234, 32'h1234, 0);
    // R3 with C=1 and then C=0
    step(4'h6, 4'hE, 0, 32'h10, 32'h3, 0);
    step(4'h2, 4'hE, 1, 32'h0, 32'h5, 0);
    step(4'h6, 4'hE, 0, 32'h10, 32'h3, 0);
    step(4'h7, 4'hE, 0, 32'h3, 32'h10, 0);
    step(4'h5, 4'hE, 1, 32'hFFFF_FFFF, 32'h1, 0);
    // R8 logical set keeps V, takes shifter carry
    step(4'h4, 4'hE, 1, 32'h8000_0000, 32'h8000_0000, 0);
    step(4'h0, 4'hE, 1, 32'hF0F0, 32'h0FF0, 1);
    // R12 MOV/MVN with garbage op_a
    step(4'hD, 4'hE, 0, 32'hDEAD_BEEF, 32'h55, 0);
    step(4'hF, 4'hE, 1, 32'hCAFE_F00D, 32'h0, 0);
    // R10 never and failing compare
    step(4'hA, 4'hF, 1, 32'h1, 32'h2, 1);
    step(4'hB, 4'h0, 1, 32'h1, 32'h2, 1);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a = $urandom, b = $urandom;
      int pick = $urandom_range(0, 7);
      if (pick == 0) b = a;
      if (pick == 1) a = 32'h8000_0000;
      if (pick == 2) b = 32'h7FFF_FFFF;
      step(4'($urandom), 4'($urandom), 1'($urandom), a, b, 1'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule